// File: doc/BRIEF.md
# Indexed Register Access Bridge

This block lets a host reach a 256-entry, byte-wide register space inside a peripheral controller through a window of only eight byte locations. The host never presents a peripheral address itself. It first places a register number in an internal pointer, then moves data through dedicated data offsets. Some of these offsets advance the pointer after the access, so a run of consecutive registers can be walked without reloading it. One offset triggers a timed reset pulse toward the peripheral.

The host side is a synchronous single-cycle bus: a 3-bit offset, byte write data, byte read data, and separate read and write strobes. Read data is combinational from the offset and strobe in the same cycle. On the peripheral side the bridge drives the pointer as the register address, forwards write data, issues read and write strobes in the same cycle as the host access, and returns the peripheral's read byte. Pointer changes take effect at the clock edge that ends the access.

Top module: `regWindowBridge`

## Requirements
- R1: While and after the active-low reset, the pointer (visible on perAddr) is 0x00, perReset is low and no peripheral strobe is active.
- R2: A host write at offset 1 loads hostWrData into the pointer; perAddr shows the new value from the next cycle.
- R3: A host read at offset 2 asserts perRd in the same cycle with perAddr equal to the pointer, returns perRdData on hostRdData, and leaves the pointer unchanged.
- R4: A host read at offset 3 behaves like offset 2 and then adds one to the pointer at the end of the cycle.
- R5: A host read at offset 5 returns the pointer value on hostRdData and produces no peripheral strobe.
- R6: A host write at offset 6 asserts perWr in the same cycle with perWrData equal to hostWrData at address perAddr, and leaves the pointer unchanged.
- R7: A host write at offset 7 behaves like offset 6 and then adds one to the pointer at the end of the cycle.
- R8: Every pointer increment wraps from 0xFF to 0x00.
- R9: Host reads at offsets 0, 1, 4, 6 and 7 return 0x00 and produce no peripheral strobe.
- R10: Host writes at offsets 2, 3, 4 and 5 produce no peripheral strobe, leave the pointer unchanged and leave perReset unchanged in its course.
- R11: A host write at offset 0 drives perReset high from the next cycle for exactly RST_CYCLES cycles; a further write at offset 0 restarts the count, so perReset falls RST_CYCLES cycles after the most recent such write.
- R12: When hostRd and hostWr are both high, the write is performed and the read is ignored: no perRd, hostRdData is 0x00, and no read-caused increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostOffset | input | 3 | Byte offset within the host window |
| hostWrData | input | 8 | Host write byte |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostRdData | output | 8 | Host read byte, valid in the cycle of hostRd |
| perAddr | output | 8 | Peripheral register address (current pointer) |
| perWrData | output | 8 | Peripheral write byte |
| perRdData | input | 8 | Peripheral read byte for perAddr |
| perRd | output | 1 | Peripheral read strobe |
| perWr | output | 1 | Peripheral write strobe |
| perReset | output | 1 | Active-high reset toward the peripheral |

## Verification
Strobes, forwarded write data and host read data are due in the very cycle of the host access, so the bench drives inputs on the falling edge and compares them a short delay later in the same low phase. Pointer effects (load, increment, wrap) appear on perAddr one cycle later, and perReset rises one cycle after an offset-0 write and falls RST_CYCLES cycles after the latest one; the reference model updates its state only after each rising edge, so every comparison in the next low phase sees exactly one edge's worth of change.

// File: rtl/regWindowPkg.sv
package regWindowPkg;

  localparam int OFF_W = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_KICK     = 3'd0,
    OFF_PTR_LD   = 3'd1,
    OFF_PEEK     = 3'd2,
    OFF_PEEK_INC = 3'd3,
    OFF_SPARE    = 3'd4,
    OFF_PTR_RD   = 3'd5,
    OFF_POKE     = 3'd6,
    OFF_POKE_INC = 3'd7
  } winOffset_e;

  // Strobes the control hands to the datapath each cycle
  typedef struct packed {
    logic loadPtr;
    logic incPtr;
    logic selPerData;
    logic selPtr;
  } ctlStrobes_t;

endpackage

// File: rtl/regWindowCtl.sv
module regWindowCtl
  import regWindowPkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OFF_W-1:0] hostOffset,
  input  logic             hostRd,
  input  logic             hostWr,
  output ctlStrobes_t      strobes,
  output logic             perRd,
  output logic             perWr,
  output logic             perReset
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  winOffset_e  offDec;
  logic        rdEff;
  logic        wrEff;
  logic        kick;
  logic [CNT_W-1:0] rstCnt;

  assign offDec = winOffset_e'(hostOffset);
  // A write wins over a simultaneous read
  assign wrEff  = hostWr;
  assign rdEff  = hostRd && !hostWr;

  always_comb begin
    strobes = '0;
    perRd   = 1'b0;
    perWr   = 1'b0;
    kick    = 1'b0;
    if (wrEff) begin
      unique case (offDec)
        OFF_KICK:     kick = 1'b1;
        OFF_PTR_LD:   strobes.loadPtr = 1'b1;
        OFF_POKE:     perWr = 1'b1;
        OFF_POKE_INC: begin
          perWr          = 1'b1;
          strobes.incPtr = 1'b1;
        end
        default: ;
      endcase
    end else if (rdEff) begin
      unique case (offDec)
        OFF_PEEK: begin
          perRd              = 1'b1;
          strobes.selPerData = 1'b1;
        end
        OFF_PEEK_INC: begin
          perRd              = 1'b1;
          strobes.selPerData = 1'b1;
          strobes.incPtr     = 1'b1;
        end
        OFF_PTR_RD: strobes.selPtr = 1'b1;
        default: ;
      endcase
    end
  end

  // Reset pulse timer, restarted by every kick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (kick) begin
      rstCnt <= CNT_W'(RST_CYCLES);
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - CNT_W'(1);
    end
  end

  assign perReset = (rstCnt != '0);

endmodule

// File: rtl/regWindowDp.sv
module regWindowDp
  import regWindowPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] perRdData,
  output logic [ADDR_W-1:0] perAddr,
  output logic [DATA_W-1:0] perWrData,
  output logic [DATA_W-1:0] hostRdData
);

  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] ptrNext;

  // Increment wraps naturally at the pointer width
  always_comb begin
    ptrNext = ptrQ;
    if (strobes.loadPtr) begin
      ptrNext = ADDR_W'(hostWrData);
    end else if (strobes.incPtr) begin
      ptrNext = ptrQ + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else begin
      ptrQ <= ptrNext;
    end
  end

  always_comb begin
    hostRdData = '0;
    if (strobes.selPerData) begin
      hostRdData = perRdData;
    end else if (strobes.selPtr) begin
      hostRdData = DATA_W'(ptrQ);
    end
  end

  assign perAddr   = ptrQ;
  assign perWrData = hostWrData;

endmodule

// File: rtl/regWindowBridge.sv
module regWindowBridge
  import regWindowPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        hostOffset,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRd,
  input  logic              hostWr,
  output logic [DATA_W-1:0] hostRdData,
  output logic [ADDR_W-1:0] perAddr,
  output logic [DATA_W-1:0] perWrData,
  input  logic [DATA_W-1:0] perRdData,
  output logic              perRd,
  output logic              perWr,
  output logic              perReset
);

  ctlStrobes_t strobes;

  regWindowCtl #(
    .RST_CYCLES(RST_CYCLES)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .hostOffset(hostOffset),
    .hostRd    (hostRd),
    .hostWr    (hostWr),
    .strobes   (strobes),
    .perRd     (perRd),
    .perWr     (perWr),
    .perReset  (perReset)
  );

  regWindowDp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostWrData(hostWrData),
    .perRdData (perRdData),
    .perAddr   (perAddr),
    .perWrData (perWrData),
    .hostRdData(hostRdData)
  );

endmodule

// File: rtl/regWindowChk.sv
module regWindowChk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        hostOffset,
  input logic [DATA_W-1:0] hostWrData,
  input logic              hostRd,
  input logic              hostWr,
  input logic [DATA_W-1:0] hostRdData,
  input logic [ADDR_W-1:0] perAddr,
  input logic [DATA_W-1:0] perWrData,
  input logic [DATA_W-1:0] perRdData,
  input logic              perRd,
  input logic              perWr,
  input logic              perReset
);

  localparam int LIM   = RST_CYCLES + 1;
  localparam int SCN_W = $clog2(LIM + 1) + 1;

  logic rdOnly;
  logic [SCN_W-1:0] sinceKick;

  assign rdOnly = hostRd && !hostWr;

  // Cycles since the latest kick, saturating; starts saturated
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceKick <= SCN_W'(LIM);
    end else if (hostWr && hostOffset == 3'd0) begin
      sinceKick <= SCN_W'(1);
    end else if (sinceKick < SCN_W'(LIM)) begin
      sinceKick <= sinceKick + SCN_W'(1);
    end
  end

  assert_idle_R1: assert property (@(posedge clk)
    !rstN |-> (perAddr == '0 && !perReset));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostOffset == 3'd1) |=> perAddr == ADDR_W'($past(hostWrData)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdOnly && hostOffset == 3'd2) |=> $stable(perAddr));

  assert_inc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdOnly && hostOffset == 3'd3) |=> perAddr == $past(perAddr) + ADDR_W'(1));

  assert_ptrRead_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdOnly && hostOffset == 3'd5) |-> (hostRdData == DATA_W'(perAddr) && !perRd && !perWr));

  assert_inc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostOffset == 3'd7) |=> perAddr == $past(perAddr) + ADDR_W'(1));

  assert_zeroRead_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdOnly && (hostOffset == 3'd0 || hostOffset == 3'd1 || hostOffset == 3'd4 ||
                hostOffset == 3'd6 || hostOffset == 3'd7))
    |-> (hostRdData == '0 && !perRd));

  assert_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostOffset >= 3'd2 && hostOffset <= 3'd5) |=> $stable(perAddr));

  assert_rstOn_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sinceKick >= SCN_W'(1) && sinceKick <= SCN_W'(RST_CYCLES)) |-> perReset);

  assert_rstOff_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sinceKick > SCN_W'(RST_CYCLES)) |-> !perReset);

  assert_writeWins_R12: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostWr) |-> (!perRd && hostRdData == '0));

  assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(perRd && perWr));

endmodule

bind regWindowBridge regWindowChk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostOffset(hostOffset),
  .hostWrData(hostWrData),
  .hostRd    (hostRd),
  .hostWr    (hostWr),
  .hostRdData(hostRdData),
  .perAddr   (perAddr),
  .perWrData (perWrData),
  .perRdData (perRdData),
  .perRd     (perRd),
  .perWr     (perWr),
  .perReset  (perReset)
);

// File: tb/regWindowBridge_tb.sv
`timescale 1ns/1ps
module regWindowBridge_tb;

  localparam int RST_CYCLES = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostOffset = '0;
  logic [7:0] hostWrData = '0;
  logic       hostRd = 1'b0;
  logic       hostWr = 1'b0;
  logic [7:0] hostRdData;
  logic [7:0] perAddr;
  logic [7:0] perWrData;
  logic [7:0] perRdData;
  logic       perRd;
  logic       perWr;
  logic       perReset;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Reference model state
  int mPtr = 0;
  int mRstCnt = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] regVal(input logic [7:0] a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  // Bench-side peripheral: fixed contents computed from the address
  assign perRdData = regVal(perAddr);

  regWindowBridge #(.RST_CYCLES(RST_CYCLES)) u_dut (
    .clk(clk), .rstN(rstN), .hostOffset(hostOffset), .hostWrData(hostWrData),
    .hostRd(hostRd), .hostWr(hostWr), .hostRdData(hostRdData),
    .perAddr(perAddr), .perWrData(perWrData), .perRdData(perRdData),
    .perRd(perRd), .perWr(perWr), .perReset(perReset)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] off, input logic [7:0] wd,
                      input logic rd, input logic wr, input string tag);
    bit wrEff, rdEff, eRd, eWr;
    int eData;
    @(negedge clk);
    hostOffset = off; hostWrData = wd; hostRd = rd; hostWr = wr;
    #2;
    wrEff = wr;
    rdEff = rd && !wr;
    eRd = rdEff && (off == 3'd2 || off == 3'd3);
    eWr = wrEff && (off == 3'd6 || off == 3'd7);
    eData = 0;
    if (rdEff && (off == 3'd2 || off == 3'd3)) eData = int'(regVal(8'(mPtr)));
    else if (rdEff && off == 3'd5) eData = mPtr;
    cmp(tag, "perAddr", int'(perAddr), mPtr);
    cmp(tag, "perRd", int'(perRd), int'(eRd));
    cmp(tag, "perWr", int'(perWr), int'(eWr));
    cmp(tag, "hostRdData", int'(hostRdData), eData);
    cmp(tag, "perReset", int'(perReset), int'(mRstCnt > 0));
    if (eWr) cmp(tag, "perWrData", int'(perWrData), int'(wd));
    @(posedge clk);
    #1;
    if (rstN) begin
      if (wrEff && off == 3'd1) mPtr = int'(wd);
      else if ((wrEff && off == 3'd7) || (rdEff && off == 3'd3)) mPtr = (mPtr + 1) % 256;
      if (wrEff && off == 3'd0) mRstCnt = RST_CYCLES;
      else if (mRstCnt > 0) mRstCnt--;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(3'd0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  initial begin
    // R1: reset state, while held and after release
    idle(3, "R1");
    @(negedge clk); rstN = 1'b1;
    idle(2, "R1");

    // R2 load, R3 plain read, R4 incrementing reads, R5 pointer read
    step(3'd1, 8'h10, 1'b0, 1'b1, "R2");
    step(3'd2, 8'h00, 1'b1, 1'b0, "R3");
    step(3'd2, 8'h00, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 3; i++) step(3'd3, 8'h00, 1'b1, 1'b0, "R4");
    step(3'd5, 8'h00, 1'b1, 1'b0, "R5");

    // R6 plain write, R7 incrementing writes
    step(3'd6, 8'hA5, 1'b0, 1'b1, "R6");
    step(3'd7, 8'h3C, 1'b0, 1'b1, "R7");
    step(3'd7, 8'hC3, 1'b0, 1'b1, "R7");
    step(3'd5, 8'h00, 1'b1, 1'b0, "R5");

    // R8: wrap by reads and by writes
    step(3'd1, 8'hFE, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 3; i++) step(3'd3, 8'h00, 1'b1, 1'b0, "R8");
    step(3'd5, 8'h00, 1'b1, 1'b0, "R8");
    step(3'd1, 8'hFF, 1'b0, 1'b1, "R2");
    step(3'd7, 8'h77, 1'b0, 1'b1, "R8");
    step(3'd5, 8'h00, 1'b1, 1'b0, "R8");

    // R9: reads that return zero
    step(3'd1, 8'h42, 1'b0, 1'b1, "R2");
    step(3'd0, 8'h00, 1'b1, 1'b0, "R9");
    step(3'd1, 8'h00, 1'b1, 1'b0, "R9");
    step(3'd4, 8'h00, 1'b1, 1'b0, "R9");
    step(3'd6, 8'h00, 1'b1, 1'b0, "R9");
    step(3'd7, 8'h00, 1'b1, 1'b0, "R9");

    // R10: writes that are ignored; pointer checked through offset 5
    step(3'd2, 8'h99, 1'b0, 1'b1, "R10");
    step(3'd3, 8'h98, 1'b0, 1'b1, "R10");
    step(3'd4, 8'h97, 1'b0, 1'b1, "R10");
    step(3'd5, 8'h96, 1'b0, 1'b1, "R10");
    step(3'd5, 8'h00, 1'b1, 1'b0, "R10");

    // R11: single kick, then retriggered kick
    step(3'd0, 8'h00, 1'b0, 1'b1, "R11");
    idle(RST_CYCLES + 3, "R11");
    step(3'd0, 8'h00, 1'b0, 1'b1, "R11");
    idle(5, "R11");
    step(3'd0, 8'hFF, 1'b0, 1'b1, "R11");
    idle(RST_CYCLES + 3, "R11");

    // R10: ignored write while reset pulse runs
    step(3'd0, 8'h00, 1'b0, 1'b1, "R11");
    step(3'd4, 8'h12, 1'b0, 1'b1, "R10");
    idle(RST_CYCLES + 1, "R10");

    // R12: read and write together
    step(3'd1, 8'h20, 1'b0, 1'b1, "R2");
    step(3'd3, 8'h00, 1'b1, 1'b1, "R12");
    step(3'd7, 8'h5E, 1'b1, 1'b1, "R12");
    step(3'd6, 8'hE5, 1'b1, 1'b1, "R12");
    step(3'd1, 8'h80, 1'b1, 1'b1, "R12");
    step(3'd5, 8'h00, 1'b1, 1'b0, "R12");

    // R1: reset in mid-operation clears pointer and pulse
    step(3'd0, 8'h00, 1'b0, 1'b1, "R11");
    @(negedge clk); rstN = 1'b0; mPtr = 0; mRstCnt = 0;
    idle(2, "R1");
    @(negedge clk); rstN = 1'b1;
    idle(2, "R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule